// File: doc/BRIEF.md
# Command Packet Taskfile Loader

This block executes one command packet that already sits in a byte-addressed local buffer. After a start pulse it reads the packet's control and length bytes from the header. It then walks a self-describing list of value/register byte pairs. Each pair becomes one write on a taskfile stream of register code, data byte and handshake. When the list is exhausted, packets that carry a data phase hand their scatter-list pointer to a downstream DMA walker and wait for its completion report. A completion code is then written back into header byte 0.

The buffer read port has a fixed latency of one cycle: data for an address presented with `buf_rd_en` is valid on `buf_rd_data` in the following cycle. The taskfile stream and the scatter-list stream are valid/ready. While `valid` is high and `ready` is low, the payload stays frozen and the block waits for as long as needed. A transfer takes place on every clock edge where both are high. Status pins (`busy`, `done`, `irq`, the error flags) and the `xfer_done` report are plain signals.

Packet layout used by the block: byte 0 response code; byte 2 control, with bit 0 valid, bit 2 data phase, bit 3 interrupt enable; byte 3 length L, where the packet size is (L+2)*8 bytes; bytes 8 to 11 scatter-list pointer, least significant byte first; register list from byte 16. In each list entry the value byte comes first and the address byte second. In the address byte, bit 7 marks the last entry, bit 5 marks an entry to skip, and bits 4:0 are the register code.

Top module: `tfl_loader`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `irq`, `tf_valid`, `sg_valid`, `buf_wr_en` and all error flags are 0.
- R2: If control bit 0 (valid) of byte 2 is clear, the block makes no taskfile write, no hand-off and no write-back. It raises `err_proto` and pulses `done`.
- R3: Each list entry at bytes 16+2k (value) and 17+2k (address) that is not skipped produces exactly one taskfile write, with `tf_reg` = address bits 4:0 and `tf_data` = the value byte. Writes are issued strictly in list order, so the high-order bytes of a 48-bit address precede the low-order bytes written to the same codes.
- R4: An entry whose address byte has bit 5 set produces no taskfile write.
- R5: An entry whose address byte has bit 7 set is the last one. No byte after it is used as a list entry, and this holds even when its bit 5 is also set.
- R6: The list may occupy bytes up to (L+2)*8-1. If that bound is reached without a last entry (including L=0), the block raises `err_len` with no hand-off and no write-back. Writes already issued stand.
- R7: On the taskfile stream, while `tf_valid` is 1 and `tf_ready` is 0, `tf_valid`, `tf_reg` and `tf_data` hold.
- R8: When control bit 2 is set, after the last entry the block offers bytes 8..11 as a little-endian `sg_ptr` on the scatter-list stream (held under back-pressure). It then waits for a `xfer_done` pulse.
- R9: Write-back is one write of byte address 0. It carries 0x01 on success, or 0x80 when `xfer_done` came with `xfer_err`=1 (which also sets `err_xfer`). Without control bit 2, 0x01 is written right after the list.
- R10: Every packet ends with `done` high for exactly one cycle. `irq` is high in that same cycle exactly when control bit 3 is set.
- R11: A `start` pulse while `busy` is 1 is ignored.
- R12: The error flags keep their value after `done` until the next accepted `start` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin executing the packet in the buffer |
| busy | output | 1 | A packet is being executed |
| done | output | 1 | One-cycle end-of-packet pulse |
| irq | output | 1 | Completion interrupt, with done |
| err_proto | output | 1 | Packet was not marked valid |
| err_len | output | 1 | List overran its length |
| err_xfer | output | 1 | Data transfer reported failure |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | ADDR_W | Buffer read byte address |
| buf_rd_data | input | 8 | Buffer read data, one cycle after request |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | ADDR_W | Buffer write byte address |
| buf_wr_data | output | 8 | Completion code |
| tf_valid | output | 1 | Taskfile write offered |
| tf_ready | input | 1 | Taskfile write accepted |
| tf_reg | output | 5 | Taskfile register code |
| tf_data | output | 8 | Taskfile register value |
| sg_valid | output | 1 | Scatter-list pointer offered |
| sg_ready | input | 1 | Scatter-list pointer accepted |
| sg_ptr | output | 8*PTR_BYTES | Scatter-list pointer |
| xfer_done | input | 1 | Data transfer finished (pulse) |
| xfer_err | input | 1 | Transfer failed, valid with xfer_done |

## Verification
The hardest case to reach is a list that runs into its length bound with no last entry after some writes have already gone out. The bench needs partial writes, no hand-off and no write-back all in one packet. It builds packets whose length field cuts the list short, including a zero length, and packets whose last entry is also marked skip. It throttles `tf_ready` and delays `xfer_done`, so that every write waits under back-pressure. A behavioural walker in the bench derives the expected write sequence from the buffer bytes and compares each accepted transfer as it happens.

// File: rtl/tfl_pkg.sv
package tfl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_TAKE, ST_TFW, ST_SG, ST_XFER, ST_WB, ST_FIN
  } tfl_state_e;

  localparam int CTL_VALID_BIT = 0;
  localparam int CTL_DATA_BIT  = 2;
  localparam int CTL_IEN_BIT   = 3;
  localparam int ENT_LAST_BIT  = 7;
  localparam int ENT_SKIP_BIT  = 5;
  localparam int REG_W         = ENT_SKIP_BIT;

  localparam logic [7:0] CODE_OK   = 8'h01;
  localparam logic [7:0] CODE_FAIL = 8'h80;

  typedef struct packed {
    logic             last;
    logic             write;
    logic [REG_W-1:0] code;
  } tfl_entry_t;
endpackage

// File: rtl/tfl_entry_decode.sv
module tfl_entry_decode
  import tfl_pkg::*;
(
  input  logic             last_flag,
  input  logic             skip_flag,
  input  logic [REG_W-1:0] code,
  output tfl_entry_t       ent
);
  always_comb begin
    ent.last  = last_flag;
    ent.write = !skip_flag;
    ent.code  = code;
  end
endmodule

// File: rtl/tfl_ptr_collect.sv
module tfl_ptr_collect #(
  parameter int PTR_BYTES = 4,
  localparam int LANE_W   = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   load,
  input  logic [LANE_W-1:0]      lane,
  input  logic [7:0]             din,
  output logic [8*PTR_BYTES-1:0] ptr
);
  for (genvar g = 0; g < PTR_BYTES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ptr[8*g +: 8] <= '0;
      else if (clr)                              ptr[8*g +: 8] <= '0;
      else if (load && lane == LANE_W'(g))       ptr[8*g +: 8] <= din;
    end
  end
endmodule

// File: rtl/tfl_loader.sv
module tfl_loader
  import tfl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PTR_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   irq,
  output logic                   err_proto,
  output logic                   err_len,
  output logic                   err_xfer,
  output logic                   buf_rd_en,
  output logic [ADDR_W-1:0]      buf_rd_addr,
  input  logic [7:0]             buf_rd_data,
  output logic                   buf_wr_en,
  output logic [ADDR_W-1:0]      buf_wr_addr,
  output logic [7:0]             buf_wr_data,
  output logic                   tf_valid,
  input  logic                   tf_ready,
  output logic [REG_W-1:0]       tf_reg,
  output logic [7:0]             tf_data,
  output logic                   sg_valid,
  input  logic                   sg_ready,
  output logic [8*PTR_BYTES-1:0] sg_ptr,
  input  logic                   xfer_done,
  input  logic                   xfer_err
);
  localparam int HDR_CTL   = 2;
  localparam int HDR_LEN   = 3;
  localparam int PTR_BASE  = 8;
  localparam int PTR_LAST  = PTR_BASE + PTR_BYTES - 1;
  localparam int LIST_BASE = PTR_BASE + 2 * PTR_BYTES;
  localparam int LANE_W    = (PTR_BYTES > 1) ? $clog2(PTR_BYTES) : 1;

  tfl_state_e       state;
  logic [ADDR_W-1:0] idx, lim;
  logic [7:0]       len_q, val_q, tf_data_q;
  logic [REG_W-1:0] tf_reg_q;
  logic             f_valid, f_data, f_ien, last_q;
  logic             in_ptr, overrun, accept;
  tfl_entry_t       ent;
  tfl_state_e       end_state;

  assign lim       = (ADDR_W'(len_q) + ADDR_W'(2)) << 3;
  assign in_ptr    = (idx >= ADDR_W'(PTR_BASE)) && (idx <= ADDR_W'(PTR_LAST));
  assign overrun   = (idx >= ADDR_W'(LIST_BASE)) && (idx >= lim);
  assign accept    = (state == ST_IDLE) && start;
  assign end_state = f_data ? ST_SG : ST_WB;

  tfl_entry_decode u_dec (
    .last_flag (buf_rd_data[ENT_LAST_BIT]),
    .skip_flag (buf_rd_data[ENT_SKIP_BIT]),
    .code      (buf_rd_data[REG_W-1:0]),
    .ent       (ent)
  );

  tfl_ptr_collect #(.PTR_BYTES(PTR_BYTES)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .load  (state == ST_TAKE && in_ptr),
    .lane  (idx[LANE_W-1:0]),
    .din   (buf_rd_data),
    .ptr   (sg_ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      len_q     <= '0;
      val_q     <= '0;
      tf_reg_q  <= '0;
      tf_data_q <= '0;
      f_valid   <= 1'b0;
      f_data    <= 1'b0;
      f_ien     <= 1'b0;
      last_q    <= 1'b0;
      err_proto <= 1'b0;
      err_len   <= 1'b0;
      err_xfer  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          idx       <= ADDR_W'(HDR_CTL);
          len_q     <= '0;
          f_valid   <= 1'b0;
          f_data    <= 1'b0;
          f_ien     <= 1'b0;
          err_proto <= 1'b0;
          err_len   <= 1'b0;
          err_xfer  <= 1'b0;
          state     <= ST_REQ;
        end
        ST_REQ: begin
          if (overrun) begin
            err_len <= 1'b1;
            state   <= ST_FIN;
          end else begin
            state   <= ST_TAKE;
          end
        end
        ST_TAKE: begin
          if (idx == ADDR_W'(HDR_CTL)) begin
            f_valid <= buf_rd_data[CTL_VALID_BIT];
            f_data  <= buf_rd_data[CTL_DATA_BIT];
            f_ien   <= buf_rd_data[CTL_IEN_BIT];
            idx     <= ADDR_W'(HDR_LEN);
            state   <= ST_REQ;
          end else if (idx == ADDR_W'(HDR_LEN)) begin
            len_q <= buf_rd_data;
            if (!f_valid) begin
              err_proto <= 1'b1;
              state     <= ST_FIN;
            end else begin
              idx   <= ADDR_W'(PTR_BASE);
              state <= ST_REQ;
            end
          end else if (in_ptr) begin
            idx   <= (idx == ADDR_W'(PTR_LAST)) ? ADDR_W'(LIST_BASE) : idx + 1'b1;
            state <= ST_REQ;
          end else if (!idx[0]) begin
            val_q <= buf_rd_data;
            idx   <= idx + 1'b1;
            state <= ST_REQ;
          end else begin
            last_q <= ent.last;
            if (ent.write) begin
              tf_reg_q  <= ent.code;
              tf_data_q <= val_q;
              state     <= ST_TFW;
            end else if (ent.last) begin
              state <= end_state;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_REQ;
            end
          end
        end
        ST_TFW: if (tf_ready) begin
          if (last_q) begin
            state <= end_state;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_REQ;
          end
        end
        ST_SG:   if (sg_ready) state <= ST_XFER;
        ST_XFER: if (xfer_done) begin
          err_xfer <= xfer_err;
          state    <= ST_WB;
        end
        ST_WB:   state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_FIN);
  assign irq         = done && f_ien;
  assign buf_rd_en   = (state == ST_REQ) && !overrun;
  assign buf_rd_addr = idx;
  assign buf_wr_en   = (state == ST_WB);
  assign buf_wr_addr = '0;
  assign buf_wr_data = err_xfer ? CODE_FAIL : CODE_OK;
  assign tf_valid    = (state == ST_TFW);
  assign tf_reg      = tf_reg_q;
  assign tf_data     = tf_data_q;
  assign sg_valid    = (state == ST_SG);

  // R7
  tf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tf_valid && !tf_ready |=> tf_valid && $stable(tf_reg) && $stable(tf_data));
  // R8
  sg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_valid && !sg_ready |=> sg_valid && $stable(sg_ptr));
  // R2
  proto_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |-> !tf_valid && !sg_valid && !buf_wr_en);
  // R6
  len_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_len |-> !sg_valid && !buf_wr_en);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/sim_tfl_loader.sv
`timescale 1ns/1ps
module sim_tfl_loader;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, irq, err_proto, err_len, err_xfer;
  logic buf_rd_en, buf_wr_en;
  logic [11:0] buf_rd_addr, buf_wr_addr;
  logic [7:0] buf_rd_data, buf_wr_data, tf_data;
  logic tf_valid, tf_ready = 1'b1, sg_valid, sg_ready = 1'b0;
  logic [4:0] tf_reg;
  logic [31:0] sg_ptr;
  logic xfer_done = 1'b0, xfer_err = 1'b0;

  always #2 clk = ~clk;

  tfl_loader u0 (.*);

  logic [7:0] mem [0:511];
  logic [7:0] rd_q;
  always @(posedge clk) if (buf_rd_en) rd_q <= mem[buf_rd_addr[8:0]];
  assign buf_rd_data = rd_q;

  int checks = 0, errors = 0, cyc = 0;
  logic [12:0] exp_q[$];
  bit exp_proto, exp_len, exp_sg, exp_irq, cfg_xerr, stall;
  logic [7:0] exp_wb;
  logic [31:0] exp_ptr;
  int done_seen, sg_seen, wb_seen, xcnt;
  bit hold_prev; logic [12:0] hold_val;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    cyc++;
    tf_ready  = stall ? (cyc % 3 == 0) : 1'b1;
    sg_ready  = (cyc % 2 == 0);
    xfer_done = 1'b0;
    if (xcnt > 0) begin
      xcnt--;
      if (xcnt == 0) begin xfer_done = 1'b1; xfer_err = cfg_xerr; end
    end
    #1;
    if (hold_prev)
      chk(tf_valid && {tf_reg, tf_data} == hold_val, "R7", "held write",
          {tf_valid, tf_reg, tf_data}, {1'b1, hold_val});
    hold_prev = tf_valid && !tf_ready;
    hold_val  = {tf_reg, tf_data};
    if (tf_valid && tf_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected write", {tf_reg, tf_data}, 0);
      else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk({tf_reg, tf_data} == e, "R3", "taskfile write", {tf_reg, tf_data}, e);
      end
    end
    if (sg_valid && sg_ready) begin
      sg_seen++;
      chk(exp_sg && sg_ptr == exp_ptr, "R8", "sg pointer", sg_ptr, exp_ptr);
      xcnt = 4;
    end
    if (buf_wr_en) begin
      wb_seen++;
      chk(buf_wr_addr == 0 && buf_wr_data == exp_wb, "R9", "write-back",
          {buf_wr_addr, buf_wr_data}, {12'h0, exp_wb});
    end
    if (done) begin
      done_seen++;
      chk({err_proto, err_len, err_xfer} == {exp_proto, exp_len, exp_sg & cfg_xerr},
          "R10", "error flags at done", {err_proto, err_len, err_xfer},
          {exp_proto, exp_len, exp_sg & cfg_xerr});
      chk(irq == exp_irq, "R10", "irq", irq, exp_irq);
    end
    if (cyc > 150000) begin
      chk(1'b0, "WD", "watchdog", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic clear_buf();
    for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
  endtask
  task automatic hdr(input logic [7:0] ctl, input logic [7:0] len, input logic [31:0] p);
    mem[2] = ctl; mem[3] = len;
    for (int b = 0; b < 4; b++) mem[8 + b] = p[8*b +: 8];
  endtask
  task automatic ent(input int k, input logic [7:0] v, input logic [7:0] a);
    mem[16 + 2*k] = v; mem[17 + 2*k] = a;
  endtask

  // behavioural reference: walk the packet the way the requirements describe
  task automatic model();
    logic [7:0] ctl, a;
    int lim, i;
    bit ended;
    ctl = mem[2];
    exp_q.delete();
    exp_proto = !ctl[0]; exp_len = 0; exp_sg = 0; exp_irq = ctl[3];
    exp_ptr = {mem[11], mem[10], mem[9], mem[8]};
    exp_wb = cfg_xerr && ctl[2] ? 8'h80 : 8'h01;
    if (exp_proto) return;
    lim = (mem[3] + 2) * 8; i = 16; ended = 0;
    while (i < lim && !ended) begin
      a = mem[i + 1];
      if (!a[5]) exp_q.push_back({a[4:0], mem[i]});
      if (a[7]) ended = 1;
      i += 2;
    end
    exp_len = !ended;
    exp_sg = ended && ctl[2];
  endtask

  task automatic run(input string name, input bit restart_mid);
    int d0, t;
    model();
    d0 = done_seen; sg_seen = 0; wb_seen = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart_mid) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (done_seen == d0 && t < 3000) begin @(negedge clk); t++; end
    chk(done_seen == d0 + 1, "R10", {name, " done"}, done_seen - d0, 1);
    repeat (12) @(negedge clk);
    chk(done_seen == d0 + 1, "R11", {name, " single done"}, done_seen - d0, 1);
    chk(!busy, "R11", {name, " idle after"}, busy, 0);
    chk(exp_q.size() == 0, "R5", {name, " writes left"}, exp_q.size(), 0);
    chk(sg_seen == int'(exp_sg), "R8", {name, " hand-offs"}, sg_seen, exp_sg);
    chk(wb_seen == int'(!exp_proto && !exp_len), "R9", {name, " write-backs"},
        wb_seen, !exp_proto && !exp_len);
    chk({err_proto, err_len} == {exp_proto, exp_len}, "R12", {name, " flags held"},
        {err_proto, err_len}, {exp_proto, exp_len});
  endtask

  initial begin
    clear_buf();
    repeat (3) @(negedge clk);
    chk({busy, done, irq, tf_valid, sg_valid, buf_wr_en, err_proto, err_len, err_xfer} == 0,
        "R1", "reset state", {busy, tf_valid, sg_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !tf_valid && !done, "R1", "idle after reset", busy, 0);

    // 28-bit command, data phase, irq enabled, skip entry in the list
    hdr(8'h0D, 8'd2, 32'h1234_5678);
    ent(0, 8'h40, 8'h16); ent(1, 8'h08, 8'h12); ent(2, 8'h11, 8'h13);
    ent(3, 8'h22, 8'h14); ent(4, 8'h33, 8'h15); ent(5, 8'h00, 8'h0E);
    ent(6, 8'h55, 8'h20); ent(7, 8'hC8, 8'h97);
    run("lba28", 0);

    // 48-bit command, back-pressure, transfer fails
    clear_buf(); stall = 1; cfg_xerr = 1;
    hdr(8'h05, 8'd3, 32'hA1B2_C3D4);
    ent(0, 8'h40, 8'h16); ent(1, 8'h00, 8'h12); ent(2, 8'h01, 8'h13);
    ent(3, 8'h02, 8'h14); ent(4, 8'h03, 8'h15); ent(5, 8'h10, 8'h12);
    ent(6, 8'h11, 8'h13); ent(7, 8'h12, 8'h14); ent(8, 8'h13, 8'h15);
    ent(9, 8'h00, 8'h0E); ent(10, 8'h00, 8'h20); ent(11, 8'h25, 8'h97);
    run("lba48", 0);
    stall = 0; cfg_xerr = 0;

    // invalid packet
    clear_buf();
    hdr(8'h0C, 8'd2, 32'h0);
    ent(0, 8'h40, 8'h16); ent(1, 8'hC8, 8'h97);
    run("invalid", 0);
    chk(mem[0] == 8'hEE && wb_seen == 0, "R2", "no write-back", wb_seen, 0);

    // list without end entry
    clear_buf(); stall = 1;
    hdr(8'h0D, 8'd1, 32'h0);
    ent(0, 8'h01, 8'h12); ent(1, 8'h02, 8'h13); ent(2, 8'h03, 8'h34);
    ent(3, 8'h04, 8'h15); ent(4, 8'h99, 8'h97);
    run("overrun", 0);
    chk(err_len && sg_seen == 0, "R6", "overrun flag", err_len, 1);
    stall = 0;

    // zero length
    clear_buf();
    hdr(8'h05, 8'd0, 32'h0);
    ent(0, 8'hC8, 8'h97);
    run("len0", 0);

    // no data phase, irq off
    clear_buf();
    hdr(8'h01, 8'd0 + 8'd1, 32'hFFFF_FFFF);
    ent(0, 8'h40, 8'h16); ent(1, 8'hEC, 8'h97);
    run("nodata", 0);
    chk(irq == 0 && sg_seen == 0 && err_len == 0, "R12", "flags cleared", err_len, 0);

    // last entry also skipped; a second start while busy
    clear_buf();
    hdr(8'h05, 8'd1, 32'h0BAD_F00D);
    ent(0, 8'h07, 8'h17); ent(1, 8'h00, 8'hA0); ent(2, 8'h66, 8'h12);
    run("skiplast", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule